// File: doc/BRIEF.md
# Multi-Rail DVFS Transition Sequencer

This block carries a performance-state change across three supply rails (CPU, core and GPU) and the system clock. A governor asks for a state index. The sequencer looks up that state's per-rail voltage codes and its frequency select in a table held on its inputs, then runs the change in a safe order. The order depends on the direction of the change, and the direction is judged by comparing the new frequency select with the one applied now. When the clock is going up, every rail is ramped first and the clock moves only after the rails are proven ready. When the clock is going down (or staying the same), the clock moves first and the rails follow once the PLL has relocked.

Rail starts go out one at a time to external slew engines, in a fixed order and a programmable number of cycles apart. Readiness waits for the slowest rail. If the rails time out, if a rail reports a reading out of window, if a command error is flagged, or if the PLL fails to lock in time, the sequencer abandons the request and rolls back to a safe operating point. The safe point has its own voltage codes and frequency select, with the voltages raised before the clock is lowered. It then counts the fault and waits out a hold-off before it takes any further request.

Top module: `dvfs_seq`

## Requirements
- R1: A transition pulses `rail_go` for rail 0 (CPU), then rail 1 (core), then rail 2 (GPU), one rail per cycle, with exactly `stagger_cyc` cycles between successive pulses (a value of 0 acts as 1). Each pulse is accompanied by `rail_tgt` slice i (bits i*VW upward) holding that rail's code.
- R2: When the target's frequency select is greater than `freq_sel`, all three rails start first. `freq_req` pulses, with `freq_sel` set to the target's select, only after every rail shows `rail_pg`, `rail_done` and `rail_inwin` high.
- R3: When the target's frequency select is not greater than `freq_sel`, `freq_req` pulses first. No rail starts until `pll_lock` has been seen high again.
- R4: `busy` falls no earlier than the cycle after the last rail's power-good rises. Readiness ignores the first cycle after the last start, and slew engines must drop `rail_done` in the cycle after a start.
- R5: If the rails are not all ready within `pg_timeout` cycles of the last start, a fault is raised and the sequencer rolls back. Rollback ramps the rails to `safe_vcode` and then sets `freq_sel` to `safe_fsel`. It ends with `at_safe` high.
- R6: If all rails are ready but any `rail_inwin` bit is low, a fault is raised and the sequencer rolls back.
- R7: `cmd_err` high during a non-rollback transition raises a fault and starts rollback.
- R8: If `pll_lock` does not return within `pg_timeout` cycles of `freq_req`, this counts as a PLL-unlock fault and starts rollback.
- R9: Each fault sets `fault` and increments `fault_cnt`, which saturates at its all-ones value. `fault` stays set until a later transition completes normally.
- R10: After a rollback completes, `busy` stays high for at least HOLDOFF cycles after the PLL relock before another request is taken.
- R11: `freq_sel` changes only in a cycle with `freq_req` high. This never happens while a rail is ramping.
- R12: A request made while `busy` is held and carried out after the current transition ends.
- R13: A request for the current state, when not at the safe point, completes at once. `busy`, `rail_go` and `freq_req` all stay low.
- R14: After reset `busy`, `fault`, `fault_cnt`, `rail_go`, `freq_sel` and `freq_req` are 0, and `at_safe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe for one cycle |
| req_idx | input | SW | Requested state index |
| vcode_tab | input | NUM_STATES*3*VW | Per-state, per-rail voltage codes; state s, rail r at bit (s*3+r)*VW |
| fsel_tab | input | NUM_STATES*FW | Per-state frequency select; state s at bit s*FW |
| safe_vcode | input | 3*VW | Rollback voltage codes, rail r at bit r*VW |
| safe_fsel | input | FW | Rollback frequency select |
| stagger_cyc | input | CW | Cycles between successive rail starts |
| pg_timeout | input | CW | Readiness and lock timeout in cycles |
| rail_tgt | output | 3*VW | Per-rail voltage target |
| rail_go | output | 3 | Per-rail start pulse |
| rail_pg | input | 3 | Per-rail power good |
| rail_done | input | 3 | Per-rail ramp finished |
| rail_inwin | input | 3 | Per-rail telemetry within window |
| cmd_err | input | 1 | Command error indication |
| freq_sel | output | FW | Applied frequency select |
| freq_req | output | 1 | Frequency change pulse |
| pll_lock | input | 1 | PLL lock acknowledge |
| busy | output | 1 | Transition, rollback or hold-off in progress |
| fault | output | 1 | Sticky fault flag |
| fault_cnt | output | FAULT_W | Saturating fault count |
| cur_state | output | SW | Last state reached normally |
| at_safe | output | 1 | Operating at the safe point |

## Verification
The hardest situations to reach from the ports are the failure paths that cut in part-way through a transition. Examples are a power-good that never comes on one rail, telemetry that reads out of window at the very moment all rails look ready, and a PLL that never relocks. Each needs the fault to persist just long enough and then clear, so that the rollback itself can finish. The bench's rail and PLL models take force flags for this. They release the flags when the rollback's first rail start appears. The bench then checks the safe targets, the fault count and the hold-off length. Counter saturation is reached by repeated command-error pulses injected a few cycles into each transition.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
    localparam int NRAIL = 3;
    localparam int RIW   = 2;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RAIL,
        SQ_CLK,
        SQ_HOLD
    } sq_state_e;
endpackage

// File: rtl/dvfs_tbl_pick.sv
module dvfs_tbl_pick #(
    parameter int NUM_STATES = 4,
    parameter int SW         = 2,
    parameter int VW         = 8,
    parameter int FW         = 4
) (
    input  logic [NUM_STATES*dvfs_pkg::NRAIL*VW-1:0] vtab,
    input  logic [NUM_STATES*FW-1:0]                 ftab,
    input  logic [SW-1:0]                            idx,
    output logic [dvfs_pkg::NRAIL*VW-1:0]            vsel,
    output logic [FW-1:0]                            fsel
);
    localparam int ROW = dvfs_pkg::NRAIL * VW;

    always_comb begin
        vsel = '0;
        fsel = '0;
        for (int s = 0; s < NUM_STATES; s++) begin
            if (idx == SW'(s)) begin
                vsel = vtab[s*ROW +: ROW];
                fsel = ftab[s*FW +: FW];
            end
        end
    end
endmodule

// File: rtl/dvfs_rail_judge.sv
module dvfs_rail_judge #(
    parameter int NR = 3
) (
    input  logic [NR-1:0] pg,
    input  logic [NR-1:0] done,
    input  logic [NR-1:0] inwin,
    output logic          all_ready,
    output logic          all_inwin
);
    logic [NR-1:0] rdy;

    for (genvar i = 0; i < NR; i++) begin : g_rail
        assign rdy[i] = pg[i] & done[i];
    end

    assign all_ready = &rdy;
    assign all_inwin = &inwin;
endmodule

// File: rtl/dvfs_sat_ctr.sv
module dvfs_sat_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq #(
    parameter int NUM_STATES = 4,
    parameter int VW         = 8,
    parameter int FW         = 4,
    parameter int CW         = 12,
    parameter int FAULT_W    = 4,
    parameter int HOLDOFF    = 32,
    localparam int SW        = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1,
    localparam int NR        = dvfs_pkg::NRAIL
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [SW-1:0]              req_idx,
    input  logic [NUM_STATES*NR*VW-1:0] vcode_tab,
    input  logic [NUM_STATES*FW-1:0]   fsel_tab,
    input  logic [NR*VW-1:0]           safe_vcode,
    input  logic [FW-1:0]              safe_fsel,
    input  logic [CW-1:0]              stagger_cyc,
    input  logic [CW-1:0]              pg_timeout,
    output logic [NR*VW-1:0]           rail_tgt,
    output logic [NR-1:0]              rail_go,
    input  logic [NR-1:0]              rail_pg,
    input  logic [NR-1:0]              rail_done,
    input  logic [NR-1:0]              rail_inwin,
    input  logic                       cmd_err,
    output logic [FW-1:0]              freq_sel,
    output logic                       freq_req,
    input  logic                       pll_lock,
    output logic                       busy,
    output logic                       fault,
    output logic [FAULT_W-1:0]         fault_cnt,
    output logic [SW-1:0]              cur_state,
    output logic                       at_safe
);
    import dvfs_pkg::*;

    typedef struct packed {
        sq_state_e       st;
        logic            up;
        logic            rb;
        logic [SW-1:0]   tgt_idx;
        logic [RIW-1:0]  ridx;
        logic [CW-1:0]   cnt;
        logic [NR*VW-1:0] newv;
        logic [FW-1:0]   newf;
        logic [NR*VW-1:0] rtgt;
        logic [FW-1:0]   fsel;
        logic [NR-1:0]   go;
        logic            freq_req;
        logic            pend;
        logic [SW-1:0]   pend_idx;
        logic            fault;
        logic [SW-1:0]   cur_idx;
        logic            at_safe;
    } seq_t;

    seq_t q, d;

    logic [SW-1:0]    take_idx;
    logic [NR*VW-1:0] pick_v;
    logic [FW-1:0]    pick_f;
    logic             all_ready, all_inwin;
    logic             fault_inc;

    assign take_idx = req_valid ? req_idx : q.pend_idx;

    dvfs_tbl_pick #(
        .NUM_STATES(NUM_STATES), .SW(SW), .VW(VW), .FW(FW)
    ) u_pick (
        .vtab(vcode_tab), .ftab(fsel_tab), .idx(take_idx),
        .vsel(pick_v), .fsel(pick_f)
    );

    dvfs_rail_judge #(.NR(NR)) u_judge (
        .pg(rail_pg), .done(rail_done), .inwin(rail_inwin),
        .all_ready(all_ready), .all_inwin(all_inwin)
    );

    dvfs_sat_ctr #(.W(FAULT_W)) u_fcnt (
        .clk(clk), .rst_n(rst_n), .inc(fault_inc), .cnt(fault_cnt)
    );

    always_comb begin
        logic do_fault;
        logic rails_ok;
        logic clk_ok;
        logic finish;

        d          = q;
        d.go       = '0;
        d.freq_req = 1'b0;
        do_fault   = 1'b0;
        rails_ok   = 1'b0;
        clk_ok     = 1'b0;
        finish     = 1'b0;

        if (req_valid && q.st != SQ_IDLE) begin
            d.pend     = 1'b1;
            d.pend_idx = req_idx;
        end

        case (q.st)
            SQ_IDLE: begin
                if (req_valid || q.pend) begin
                    d.pend = 1'b0;
                    if (!(take_idx == q.cur_idx && !q.at_safe)) begin
                        d.tgt_idx = take_idx;
                        d.rb      = 1'b0;
                        d.newv    = pick_v;
                        d.newf    = pick_f;
                        d.up      = pick_f > q.fsel;
                        d.cnt     = '0;
                        d.ridx    = '0;
                        if (pick_f > q.fsel) begin
                            d.st = SQ_RAIL;
                        end else begin
                            d.fsel     = pick_f;
                            d.freq_req = 1'b1;
                            d.st       = SQ_CLK;
                        end
                    end
                end
            end

            SQ_RAIL: begin
                if (cmd_err && !q.rb) begin
                    do_fault = 1'b1;
                end else if (q.ridx == '0 ||
                             (q.ridx != RIW'(NR) && (q.cnt + CW'(1)) >= stagger_cyc)) begin
                    d.go[q.ridx]                     = 1'b1;
                    d.rtgt[int'(q.ridx)*VW +: VW]    = q.newv[int'(q.ridx)*VW +: VW];
                    d.ridx                           = q.ridx + 1'b1;
                    d.cnt                            = '0;
                end else if (q.ridx == RIW'(NR)) begin
                    if (q.cnt != '0 && all_ready) begin
                        if (all_inwin || q.rb) rails_ok = 1'b1;
                        else                   do_fault = 1'b1;
                    end else if (q.cnt >= pg_timeout) begin
                        if (q.rb) rails_ok = 1'b1;
                        else      do_fault = 1'b1;
                    end else if (q.cnt != '1) begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end

                if (rails_ok) begin
                    if (q.up) begin
                        d.fsel     = q.newf;
                        d.freq_req = 1'b1;
                        d.st       = SQ_CLK;
                        d.cnt      = '0;
                    end else begin
                        finish = 1'b1;
                    end
                end
            end

            SQ_CLK: begin
                if (cmd_err && !q.rb) begin
                    do_fault = 1'b1;
                end else if (q.cnt != '0 && pll_lock) begin
                    clk_ok = 1'b1;
                end else if (q.cnt >= pg_timeout) begin
                    if (q.rb) clk_ok = 1'b1;
                    else      do_fault = 1'b1;
                end else if (q.cnt != '1) begin
                    d.cnt = q.cnt + 1'b1;
                end

                if (clk_ok) begin
                    if (q.up) begin
                        finish = 1'b1;
                    end else begin
                        d.st   = SQ_RAIL;
                        d.ridx = '0;
                        d.cnt  = '0;
                    end
                end
            end

            SQ_HOLD: begin
                if ((q.cnt + CW'(1)) >= CW'(HOLDOFF)) d.st = SQ_IDLE;
                else                                  d.cnt = q.cnt + 1'b1;
            end

            default: d.st = SQ_IDLE;
        endcase

        if (finish) begin
            d.cnt = '0;
            if (q.rb) begin
                d.st      = SQ_HOLD;
                d.at_safe = 1'b1;
            end else begin
                d.st      = SQ_IDLE;
                d.cur_idx = q.tgt_idx;
                d.at_safe = 1'b0;
                d.fault   = 1'b0;
            end
        end

        if (do_fault) begin
            d.fault = 1'b1;
            d.rb    = 1'b1;
            d.up    = 1'b1;
            d.newv  = safe_vcode;
            d.newf  = safe_fsel;
            d.st    = SQ_RAIL;
            d.ridx  = '0;
            d.cnt   = '0;
        end

        fault_inc = do_fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= SQ_IDLE;
            q.at_safe  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rail_tgt  = q.rtgt;
    assign rail_go   = q.go;
    assign freq_sel  = q.fsel;
    assign freq_req  = q.freq_req;
    assign busy      = (q.st != SQ_IDLE);
    assign fault     = q.fault;
    assign cur_state = q.cur_idx;
    assign at_safe   = q.at_safe;
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
    parameter int FW      = 4,
    parameter int FAULT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         rail_go,
    input logic               freq_req,
    input logic [FW-1:0]      freq_sel,
    input logic               busy,
    input logic               fault,
    input logic [FAULT_W-1:0] fault_cnt
);
    assert_one_rail_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rail_go));

    assert_clock_apart_from_rails_R11: assert property (@(posedge clk) disable iff (!rst_n)
        freq_req |-> (rail_go == 3'b000));

    assert_fsel_moves_only_on_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_sel) |-> freq_req);

    assert_activity_while_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rail_go) || freq_req) |-> busy);

    assert_fault_cnt_no_decrease_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_cnt >= $past(fault_cnt));

    assert_fault_rises_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> busy);
endmodule

bind dvfs_seq dvfs_seq_chk #(.FW(FW), .FAULT_W(FAULT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rail_go(rail_go), .freq_req(freq_req),
    .freq_sel(freq_sel), .busy(busy), .fault(fault), .fault_cnt(fault_cnt)
);

// File: tb/dvfs_seq_bench.sv
module dvfs_seq_bench;
    localparam int N  = 4;
    localparam int VW = 8;
    localparam int FW = 4;
    localparam int CW = 12;
    localparam int FCW = 4;
    localparam int HOLD = 32;
    localparam int TO = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_idx = '0;
    logic [N*3*VW-1:0] vcode_tab;
    logic [N*FW-1:0] fsel_tab;
    logic [3*VW-1:0] safe_vcode;
    logic [FW-1:0] safe_fsel = '0;
    logic [CW-1:0] stagger_cyc = CW'(4);
    logic [CW-1:0] pg_timeout = CW'(TO);
    logic [3*VW-1:0] rail_tgt;
    logic [2:0] rail_go;
    logic [2:0] m_pg = 3'b111, m_done = 3'b111, m_ramp = 3'b000;
    logic [2:0] f_nopg = 3'b000, f_outwin = 3'b000;
    logic cmd_err = 1'b0;
    logic [FW-1:0] freq_sel;
    logic freq_req;
    logic m_lock = 1'b1, p_busy = 1'b0, f_nolock = 1'b0;
    logic busy, fault, at_safe;
    logic [FCW-1:0] fault_cnt;
    logic [1:0] cur_state;

    int lat[3] = '{5, 5, 5};
    int m_cnt[3] = '{0, 0, 0};
    int pll_lat = 6, p_cnt = 0;
    int cyc = 0, n_tests = 0, n_fail = 0;
    int g_cyc[3], fr_cyc, lock_cyc, lastlow = -1;
    int go_total = 0, fr_total = 0, go0_total = 0;
    logic [FW-1:0] prev_fsel = '0;

    always #2.5 clk = ~clk;

    dvfs_seq #(.NUM_STATES(N), .VW(VW), .FW(FW), .CW(CW), .FAULT_W(FCW), .HOLDOFF(HOLD)) u_dvfs_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
        .vcode_tab(vcode_tab), .fsel_tab(fsel_tab), .safe_vcode(safe_vcode),
        .safe_fsel(safe_fsel), .stagger_cyc(stagger_cyc), .pg_timeout(pg_timeout),
        .rail_tgt(rail_tgt), .rail_go(rail_go), .rail_pg(m_pg), .rail_done(m_done),
        .rail_inwin(~f_outwin), .cmd_err(cmd_err), .freq_sel(freq_sel),
        .freq_req(freq_req), .pll_lock(m_lock), .busy(busy), .fault(fault),
        .fault_cnt(fault_cnt), .cur_state(cur_state), .at_safe(at_safe)
    );

    function automatic int vcode_of(int s, int r);
        return 40 + s * 20 + r * 3;
    endfunction
    function automatic int fsel_of(int s);
        return s * 3 + 1;
    endfunction
    function automatic int safe_v(int r);
        return 150 + r;
    endfunction

    // rail and PLL models
    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i < 3; i++) begin
            if (rail_go[i]) begin
                m_ramp[i] <= 1'b1; m_cnt[i] <= 0; m_pg[i] <= 1'b0; m_done[i] <= 1'b0;
            end else if (m_ramp[i]) begin
                if (m_cnt[i] + 1 >= lat[i]) begin
                    m_ramp[i] <= 1'b0; m_done[i] <= 1'b1; m_pg[i] <= !f_nopg[i];
                end else m_cnt[i] <= m_cnt[i] + 1;
            end
        end
        if (freq_req) begin
            m_lock <= 1'b0; p_busy <= 1'b1; p_cnt <= 0;
        end else if (p_busy) begin
            if (p_cnt + 1 >= pll_lat) begin
                p_busy <= 1'b0; m_lock <= !f_nolock;
            end else p_cnt <= p_cnt + 1;
        end else if (!m_lock && !f_nolock) m_lock <= 1'b1;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor, away from the active edge
    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) if (rail_go[i]) begin g_cyc[i] = cyc; go_total++; end
        if (rail_go[0]) go0_total++;
        if (freq_req) begin fr_cyc = cyc; fr_total++; end
        if (m_lock && lock_cyc < fr_cyc && fr_cyc >= 0) lock_cyc = cyc;
        if (!(&m_pg)) lastlow = cyc;
        if (rst_n && freq_sel != prev_fsel)
            check(m_ramp == 3'b000, "R11 clock moved while ramping", m_ramp, 0);
        prev_fsel = freq_sel;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic clear_marks();
        for (int i = 0; i < 3; i++) g_cyc[i] = -1;
        fr_cyc = -1;
        lock_cyc = -1;
    endtask

    task automatic wait_idle();
        int k = 0;
        while ((busy || req_valid) && k < 5000) begin @(negedge clk); k++; end
        check(k < 5000, "R4 transition did not end", k, 5000);
    endtask

    task automatic pulse_req(input int idx);
        @(negedge clk);
        req_valid = 1'b1; req_idx = 2'(idx);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_req(input int idx);
        bit up;
        int st;
        up = fsel_of(idx) > int'(freq_sel);
        clear_marks();
        st = int'(stagger_cyc);
        pulse_req(idx);
        wait_idle();
        check(g_cyc[1] - g_cyc[0] == st, "R1 stagger 0->1", g_cyc[1] - g_cyc[0], st);
        check(g_cyc[2] - g_cyc[1] == st, "R1 stagger 1->2", g_cyc[2] - g_cyc[1], st);
        for (int r = 0; r < 3; r++)
            check(int'(rail_tgt[r*VW +: VW]) == vcode_of(idx, r), "R1 rail target",
                  rail_tgt[r*VW +: VW], vcode_of(idx, r));
        check(int'(freq_sel) == fsel_of(idx), "R2 freq select", freq_sel, fsel_of(idx));
        if (up) begin
            check(fr_cyc > g_cyc[2] && fr_cyc > lastlow, "R2 clock after rails ready", fr_cyc, lastlow + 1);
        end else begin
            check(fr_cyc < g_cyc[0], "R3 clock before rails", fr_cyc, g_cyc[0]);
            check(lock_cyc >= 0 && g_cyc[0] > lock_cyc, "R3 rails after lock", g_cyc[0], lock_cyc + 1);
        end
        check(cyc > lastlow, "R4 done after slowest rail", cyc, lastlow + 1);
        check(fault == 1'b0, "R9 fault clears on success", fault, 0);
        check(int'(cur_state) == idx && !at_safe, "R12 state reached", cur_state, idx);
    endtask

    task automatic run_same(input int idx);
        int g0 = go_total, f0 = fr_total, b = 0;
        pulse_req(idx);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (busy) b++;
        end
        check(b == 0 && go_total == g0 && fr_total == f0, "R13 same state no activity",
              b + go_total - g0 + fr_total - f0, 0);
    endtask

    // kind: 0 no power good on GPU, 1 core out of window, 2 no lock, 3 command error
    task automatic run_fault(input int idx, input int kind, input string tag);
        int base = go0_total, k = 0;
        int exp_cnt = (int'(fault_cnt) == (1 << FCW) - 1) ? int'(fault_cnt) : int'(fault_cnt) + 1;
        clear_marks();
        if (kind == 0) f_nopg[2] = 1'b1;
        if (kind == 1) f_outwin[1] = 1'b1;
        if (kind == 2) f_nolock = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_idx = 2'(idx);
        @(negedge clk);
        req_valid = 1'b0;
        while (busy && k < 5000) begin
            if (k == 3 && kind == 3) cmd_err = 1'b1; else cmd_err = 1'b0;
            if (go0_total - base >= 2) begin f_nopg = '0; f_outwin = '0; f_nolock = 1'b0; end
            @(negedge clk);
            k++;
        end
        cmd_err = 1'b0;
        check(k < 5000, {tag, " rollback ended"}, k, 5000);
        check(fault == 1'b1, {tag, " fault flag"}, fault, 1);
        check(int'(fault_cnt) == exp_cnt, "R9 fault count", fault_cnt, exp_cnt);
        check(at_safe == 1'b1 && freq_sel == safe_fsel, "R5 safe clock", freq_sel, safe_fsel);
        for (int r = 0; r < 3; r++)
            check(int'(rail_tgt[r*VW +: VW]) == safe_v(r), "R5 safe voltage", rail_tgt[r*VW +: VW], safe_v(r));
        check(lock_cyc >= 0 && cyc - lock_cyc >= HOLD, "R10 hold-off length", cyc - lock_cyc, HOLD);
    endtask

    initial begin
        for (int s = 0; s < N; s++) begin
            for (int r = 0; r < 3; r++) vcode_tab[(s*3+r)*VW +: VW] = VW'(vcode_of(s, r));
            fsel_tab[s*FW +: FW] = FW'(fsel_of(s));
        end
        for (int r = 0; r < 3; r++) safe_vcode[r*VW +: VW] = VW'(safe_v(r));
        clear_marks();
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14 reset state
        check(!busy && !fault && fault_cnt == 0 && rail_go == 0 && freq_sel == 0 && !freq_req && at_safe,
              "R14 reset state", {busy, fault, rail_go, freq_req, at_safe}, 1);

        run_fault(2, 0, "R5");
        run_fault(1, 1, "R6");
        run_fault(3, 2, "R8");
        run_fault(2, 3, "R7");

        stagger_cyc = CW'(7);
        run_req(1);
        run_req(3);
        run_req(0);
        run_same(0);
        stagger_cyc = CW'(1);
        lat = '{3, 25, 9};
        run_req(2);

        // R12 request while busy is held and run afterwards
        pulse_req(0);
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_idx = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int k = 0;
            while (!(int'(cur_state) == 3 && !busy) && k < 5000) begin @(negedge clk); k++; end
            check(int'(cur_state) == 3 && int'(freq_sel) == fsel_of(3), "R12 held request served", cur_state, 3);
        end

        // constrained random transitions
        for (int it = 0; it < 30; it++) begin
            int idx = int'($urandom % N);
            stagger_cyc = CW'(1 + $urandom % 20);
            for (int r = 0; r < 3; r++) lat[r] = 1 + int'($urandom % 30);
            pll_lat = 1 + int'($urandom % 15);
            if (idx == int'(cur_state) && !at_safe) run_same(idx);
            else run_req(idx);
        end

        // saturation of the fault counter through repeated command errors
        stagger_cyc = CW'(2);
        for (int it = 0; it < 17; it++) run_fault(1 + it % 3, 3, "R7");
        check(int'(fault_cnt) == (1 << FCW) - 1, "R9 counter saturated", fault_cnt, (1 << FCW) - 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule